// File: doc/BRIEF.md
# Exception Arbiter

The exception arbiter watches every pending exception source of an in-order core and decides which one is signalled, and in which cycle. It handles four groups of sources: asynchronous events (hard reset, machine check, soft reset and five maskable interrupt lines), a latched instruction-fetch fault, the dispatch/execute faults carried by the oldest unretired instruction, and the trace condition raised when that instruction retires.

Some sources are acted on at once. Others wait until the machine is recoverable, which means the completed-store queue is empty and no signalled completion is still outstanding. A maskable interrupt first lets exactly one more instruction retire, then holds further completion until it is taken. Faults from an older instruction beat a waiting fetch fault, which is then discarded, and they beat the trace request of the same instruction. Every exception taken is reported as a one-cycle strobe with a 5-bit code, one clock after the deciding inputs.

Top module: `exc_arbiter`

## Requirements
- R1: During and right after reset, `exc_take`, `exc_code`, `dispatch_stop`, `cmp_halt` and `checkstop` are all 0.
- R2: `hrst_req` produces a take with code 1 on the next clock. This happens whatever else is pending and whether or not the machine is recoverable.
- R3: `mchk_req` with `mchk_en` set and no hard reset produces code 2 on the next clock, even when the machine is not recoverable. It outranks a soft reset that is pending in the same cycle, and that soft reset follows one cycle later.
- R4: `srst_req` is taken as code 3 only in a cycle where `sq_empty` and `cmpl_idle` are both 1. Until then it stays pending.
- R5: `mchk_req` with `mchk_en` clear and no hard reset sets `checkstop`, which stays at 1 until `rst`. While it is 1, no exception is taken, not even a hard reset.
- R6: When `cmp_valid` is 1 and `cmp_fault` is non-zero, the lowest set bit i is taken as code 10+i and the instruction does not retire. The bit meanings, in priority order, are: 0 address breakpoint, 1 illegal/privileged/trap, 2 system call, 3 FP unavailable, 4 FP-enabled program, 5 external-control data fault, 6 alignment, 7 block protection, 8 direct-store segment, 9 page protection, 10 data breakpoint. `cmp_fault` is ignored while `cmp_valid` is 0.
- R7: A retirement with no fault raises trace (code 21) when `trace_step` is 1, or when `trace_branch` and `cmp_branch` are both 1. A retirement that also carries a fault reports only the fault.
- R8: Interrupt line i of `irq_req` counts only while `irq_en[i]` and `irq_ee` are both 1. Among the lines that count, the lowest index wins, and line i is taken as code 4+i. The lines are 0 system management, 1 external, 2 performance monitor, 3 decrementer, 4 thermal.
- R9: A counted interrupt first waits for one fault-free retirement, then raises `cmp_halt` on the next clock and is taken once recoverable. While `cmp_halt` is 1, `cmp_valid` and `cmp_fault` are ignored.
- R10: If the instruction that a waiting interrupt needs to retire raises a fault, the fault is taken, `cmp_halt` stays 0 and the interrupt stays pending.
- R11: A `fetch_fault` pulse raises `dispatch_stop` on the next clock. The fault is taken as code 9 once `inflight_empty` is 1 and the machine is recoverable. Any other exception taken first clears it, and it is then never taken.
- R12: `exc_take` is high for one cycle per exception taken, and `exc_code` is 0 whenever `exc_take` is 0. Priority between groups, highest first: hard reset, machine check, soft reset, retiring-instruction fault or trace, maskable interrupt, fetch fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hrst_req | input | 1 | Hard or power-on reset request |
| mchk_req | input | 1 | Machine check condition |
| mchk_en | input | 1 | Machine check enable |
| srst_req | input | 1 | Soft reset request |
| irq_req | input | 5 | Maskable interrupt lines |
| irq_en | input | 5 | Per-line interrupt enable |
| irq_ee | input | 1 | Global external-interrupt enable |
| sq_empty | input | 1 | Completed-store queue drained |
| cmpl_idle | input | 1 | No signalled completion outstanding |
| cmp_valid | input | 1 | Oldest instruction presented for retirement |
| cmp_fault | input | 11 | Fault flags of the oldest instruction |
| cmp_branch | input | 1 | Oldest instruction is a branch |
| trace_step | input | 1 | Single-step trace enabled |
| trace_branch | input | 1 | Branch trace enabled |
| fetch_fault | input | 1 | Instruction-fetch fault pulse |
| inflight_empty | input | 1 | All older instructions have executed |
| exc_take | output | 1 | One-cycle take strobe |
| exc_code | output | 5 | Code of the exception taken |
| dispatch_stop | output | 1 | Dispatch held for a pending fetch fault |
| cmp_halt | output | 1 | Further retirement held for an interrupt |
| checkstop | output | 1 | Sticky checkstop |

## Verification
Two functions can land in one cycle: the retirement that a waiting maskable interrupt is counting on, and the fault that instruction raises. The bench makes an interrupt pending, then presents a retirement that carries a system-call fault. It expects the fault code, `cmp_halt` still low, and the interrupt code only after a later clean retirement. In the same spirit, a soft reset is held together with a machine check, and the scoreboard must see both codes, in priority order, in consecutive cycles.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;

    localparam int IRQ_N      = 5;
    localparam int FLT_N      = 11;
    localparam int CODE_W     = 5;
    localparam int SCAN_W     = 16;
    localparam int IRQ_BASE   = 4;
    localparam int FETCH_SLOT = IRQ_BASE + IRQ_N;
    localparam int FLT_BASE   = FETCH_SLOT + 1;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE   = 5'd0,
        EXC_HRST   = 5'd1,
        EXC_MCHK   = 5'd2,
        EXC_SRST   = 5'd3,
        EXC_SMI    = 5'd4,
        EXC_EXT    = 5'd5,
        EXC_PERF   = 5'd6,
        EXC_DEC    = 5'd7,
        EXC_THERM  = 5'd8,
        EXC_IFETCH = 5'd9,
        EXC_IABR   = 5'd10,
        EXC_PROG   = 5'd11,
        EXC_SYSC   = 5'd12,
        EXC_FPU    = 5'd13,
        EXC_FPEN   = 5'd14,
        EXC_XCTL   = 5'd15,
        EXC_ALIGN  = 5'd16,
        EXC_BLKP   = 5'd17,
        EXC_DSEG   = 5'd18,
        EXC_PAGEP  = 5'd19,
        EXC_DBRK   = 5'd20,
        EXC_TRACE  = 5'd21
    } exc_code_t;

    typedef enum logic [1:0] {
        AQ_IDLE = 2'd0,
        AQ_WAIT = 2'd1,
        AQ_HOLD = 2'd2
    } aq_state_t;

    typedef struct packed {
        logic      valid;
        exc_code_t code;
    } exc_pick_t;

    localparam exc_pick_t PICK_NONE = '{valid: 1'b0, code: EXC_NONE};

    // index of the lowest set bit; zero when none is set
    function automatic logic [CODE_W-1:0] first_one(input logic [SCAN_W-1:0] v);
        logic [CODE_W-1:0] idx;
        idx = '0;
        for (int i = SCAN_W - 1; i >= 0; i--) begin
            if (v[i]) idx = CODE_W'(i);
        end
        return idx;
    endfunction

    function automatic logic is_irq_code(input exc_code_t c);
        return (int'(c) >= IRQ_BASE) && (int'(c) < IRQ_BASE + IRQ_N);
    endfunction

endpackage

// File: rtl/exc_arb_async.sv
module exc_arb_async
    import exc_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hrst_req,
    input  logic             mchk_req,
    input  logic             mchk_en,
    input  logic             srst_req,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             irq_ee,
    input  logic             recov,
    input  logic             done_ok,
    input  logic             take_valid,
    input  exc_code_t        take_code,
    output exc_pick_t        pick_hi,
    output exc_pick_t        pick_irq,
    output logic             stop_now,
    output logic             halt
);

    logic [IRQ_N-1:0] live;
    logic             any_live;
    aq_state_t        st_q, st_d;

    assign live     = irq_req & irq_en & {IRQ_N{irq_ee}};
    assign any_live = |live;
    assign halt     = (st_q == AQ_HOLD);

    // disabled machine check stops the core unless a hard reset is there too
    assign stop_now = mchk_req & ~mchk_en & ~hrst_req;

    always_comb begin
        pick_hi = PICK_NONE;
        if (hrst_req)
            pick_hi = '{valid: 1'b1, code: EXC_HRST};
        else if (mchk_req && mchk_en)
            pick_hi = '{valid: 1'b1, code: EXC_MCHK};
        else if (srst_req && recov)
            pick_hi = '{valid: 1'b1, code: EXC_SRST};
    end

    always_comb begin
        pick_irq       = PICK_NONE;
        pick_irq.valid = halt && recov && any_live;
        if (pick_irq.valid)
            pick_irq.code = exc_code_t'(CODE_W'(IRQ_BASE)
                          + first_one({{(SCAN_W-IRQ_N){1'b0}}, live}));
    end

    // one clean retirement, then hold completion until taken
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AQ_IDLE: if (any_live) st_d = done_ok ? AQ_HOLD : AQ_WAIT;
            AQ_WAIT: begin
                if (!any_live)    st_d = AQ_IDLE;
                else if (done_ok) st_d = AQ_HOLD;
            end
            AQ_HOLD: begin
                if (!any_live || (take_valid && is_irq_code(take_code)))
                    st_d = AQ_IDLE;
            end
            default: st_d = AQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= AQ_IDLE;
        else     st_q <= st_d;
    end

    p_hold_after_retire_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q != AQ_HOLD && st_d == AQ_HOLD) |-> done_ok);

endmodule

// File: rtl/exc_arb_instr.sv
module exc_arb_instr
    import exc_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_valid,
    input  logic [FLT_N-1:0] cmp_fault,
    input  logic             cmp_branch,
    input  logic             trace_step,
    input  logic             trace_branch,
    input  logic             halt,
    input  logic             fetch_fault,
    input  logic             inflight_empty,
    input  logic             recov,
    input  logic             take_valid,
    output exc_pick_t        pick_ins,
    output exc_pick_t        pick_fetch,
    output logic             done_ok,
    output logic             fetch_pend
);

    logic live_cmp;
    logic has_flt;
    logic trace_hit;
    logic fetch_q;

    assign live_cmp   = cmp_valid & ~halt;
    assign has_flt    = |cmp_fault;
    assign done_ok    = live_cmp & ~has_flt;
    assign trace_hit  = done_ok & (trace_step | (trace_branch & cmp_branch));
    assign fetch_pend = fetch_q;

    always_comb begin
        pick_ins = PICK_NONE;
        if (live_cmp && has_flt)
            pick_ins = '{valid: 1'b1,
                         code: exc_code_t'(CODE_W'(FLT_BASE)
                             + first_one({{(SCAN_W-FLT_N){1'b0}}, cmp_fault}))};
        else if (trace_hit)
            pick_ins = '{valid: 1'b1, code: EXC_TRACE};
    end

    always_comb begin
        pick_fetch       = PICK_NONE;
        pick_fetch.valid = fetch_q && inflight_empty && recov;
        if (pick_fetch.valid) pick_fetch.code = EXC_IFETCH;
    end

    // any take clears the latched fetch fault: its own, or a winner that drops it
    always_ff @(posedge clk) begin
        if (rst)              fetch_q <= 1'b0;
        else if (fetch_fault) fetch_q <= 1'b1;
        else if (take_valid)  fetch_q <= 1'b0;
    end

    p_fetch_set_r11: assert property (@(posedge clk) disable iff (rst)
        fetch_fault |=> fetch_q);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hrst_req,
    input  logic             mchk_req,
    input  logic             mchk_en,
    input  logic             srst_req,
    input  logic [IRQ_N-1:0] irq_req,
    input  logic [IRQ_N-1:0] irq_en,
    input  logic             irq_ee,
    input  logic             sq_empty,
    input  logic             cmpl_idle,
    input  logic             cmp_valid,
    input  logic [FLT_N-1:0] cmp_fault,
    input  logic             cmp_branch,
    input  logic             trace_step,
    input  logic             trace_branch,
    input  logic             fetch_fault,
    input  logic             inflight_empty,
    output logic             exc_take,
    output logic [CODE_W-1:0] exc_code,
    output logic             dispatch_stop,
    output logic             cmp_halt,
    output logic             checkstop
);

    logic      recov;
    logic      stop_now;
    logic      halt;
    logic      done_ok;
    logic      fetch_pend;
    exc_pick_t pick_hi, pick_irq, pick_ins, pick_fetch, pick;
    logic      take_q;
    exc_code_t code_q;
    logic      chk_q;

    assign recov = sq_empty & cmpl_idle;

    exc_arb_async u_async (
        .clk        (clk),
        .rst        (rst),
        .hrst_req   (hrst_req),
        .mchk_req   (mchk_req),
        .mchk_en    (mchk_en),
        .srst_req   (srst_req),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .irq_ee     (irq_ee),
        .recov      (recov),
        .done_ok    (done_ok),
        .take_valid (pick.valid),
        .take_code  (pick.code),
        .pick_hi    (pick_hi),
        .pick_irq   (pick_irq),
        .stop_now   (stop_now),
        .halt       (halt)
    );

    exc_arb_instr u_instr (
        .clk            (clk),
        .rst            (rst),
        .cmp_valid      (cmp_valid),
        .cmp_fault      (cmp_fault),
        .cmp_branch     (cmp_branch),
        .trace_step     (trace_step),
        .trace_branch   (trace_branch),
        .halt           (halt),
        .fetch_fault    (fetch_fault),
        .inflight_empty (inflight_empty),
        .recov          (recov),
        .take_valid     (pick.valid),
        .pick_ins       (pick_ins),
        .pick_fetch     (pick_fetch),
        .done_ok        (done_ok),
        .fetch_pend     (fetch_pend)
    );

    // group priority: async high, retiring instruction, maskable, fetch
    always_comb begin
        pick = PICK_NONE;
        if (pick_hi.valid)         pick = pick_hi;
        else if (pick_ins.valid)   pick = pick_ins;
        else if (pick_irq.valid)   pick = pick_irq;
        else if (pick_fetch.valid) pick = pick_fetch;
        if (chk_q || stop_now)     pick = PICK_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            code_q <= EXC_NONE;
            chk_q  <= 1'b0;
        end else begin
            take_q <= pick.valid;
            code_q <= pick.valid ? pick.code : EXC_NONE;
            chk_q  <= chk_q | stop_now;
        end
    end

    assign exc_take      = take_q;
    assign exc_code      = code_q;
    assign dispatch_stop = fetch_pend;
    assign cmp_halt      = halt;
    assign checkstop     = chk_q;

    p_code_with_take_r12: assert property (@(posedge clk) disable iff (rst)
        exc_take == (exc_code != CODE_W'(0)));

    p_hard_reset_r2: assert property (@(posedge clk) disable iff (rst)
        (hrst_req && !checkstop) |=> (exc_take && exc_code == EXC_HRST));

    p_mchk_next_r3: assert property (@(posedge clk) disable iff (rst)
        (mchk_req && mchk_en && !hrst_req && !checkstop)
        |=> (exc_take && exc_code == EXC_MCHK));

    p_srst_recov_r4: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_code == EXC_SRST) |-> $past(sq_empty && cmpl_idle));

    p_checkstop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        checkstop |=> (checkstop && !exc_take));

    p_irq_from_halt_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_take && is_irq_code(exc_code_t'(exc_code))) |-> $past(cmp_halt));

    p_fetch_drained_r11: assert property (@(posedge clk) disable iff (rst)
        (exc_take && exc_code == EXC_IFETCH)
        |-> $past(dispatch_stop && inflight_empty && sq_empty && cmpl_idle));

endmodule

// File: tb/exc_arbiter_tb.sv
module exc_arbiter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst;
    logic        hrst_req, mchk_req, mchk_en, srst_req;
    logic [4:0]  irq_req, irq_en;
    logic        irq_ee, sq_empty, cmpl_idle, cmp_valid;
    logic [10:0] cmp_fault;
    logic        cmp_branch, trace_step, trace_branch, fetch_fault, inflight_empty;
    logic        exc_take;
    logic [4:0]  exc_code;
    logic        dispatch_stop, cmp_halt, checkstop;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [4:0]  exp_code[$];
    string       exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_arbiter u_dut (
        .clk(clk), .rst(rst), .hrst_req(hrst_req), .mchk_req(mchk_req),
        .mchk_en(mchk_en), .srst_req(srst_req), .irq_req(irq_req),
        .irq_en(irq_en), .irq_ee(irq_ee), .sq_empty(sq_empty),
        .cmpl_idle(cmpl_idle), .cmp_valid(cmp_valid), .cmp_fault(cmp_fault),
        .cmp_branch(cmp_branch), .trace_step(trace_step),
        .trace_branch(trace_branch), .fetch_fault(fetch_fault),
        .inflight_empty(inflight_empty), .exc_take(exc_take),
        .exc_code(exc_code), .dispatch_stop(dispatch_stop),
        .cmp_halt(cmp_halt), .checkstop(checkstop)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_take(input logic [4:0] c, input string tag);
        exp_code.push_back(c);
        exp_tag.push_back(tag);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick();
            check(exc_take == 1'b0, tag, int'(exc_take), 0);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // scoreboard monitor: every take must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && exc_take) begin
            if (exp_code.size() == 0) begin
                check(1'b0, "R12 take with nothing expected", int'(exc_code), 0);
            end else begin
                logic [4:0] e;
                string      t;
                e = exp_code.pop_front();
                t = exp_tag.pop_front();
                check(exc_code == e, t, int'(exc_code), int'(e));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        check(1'b0, "R12 watchdog expired", 0, 1);
        summary();
    end

    initial begin
        rst = 1'b1; hrst_req = 0; mchk_req = 0; mchk_en = 1; srst_req = 0;
        irq_req = '0; irq_en = 5'h1f; irq_ee = 0; sq_empty = 1; cmpl_idle = 1;
        cmp_valid = 0; cmp_fault = '0; cmp_branch = 0; trace_step = 0;
        trace_branch = 0; fetch_fault = 0; inflight_empty = 1;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check(exc_take == 0,      "R1 take after reset", int'(exc_take), 0);
        check(exc_code == 0,      "R1 code after reset", int'(exc_code), 0);
        check(dispatch_stop == 0, "R1 dispatch_stop", int'(dispatch_stop), 0);
        check(cmp_halt == 0,      "R1 cmp_halt", int'(cmp_halt), 0);
        check(checkstop == 0,     "R1 checkstop", int'(checkstop), 0);

        // R2 hard reset beats everything, not recoverable
        hrst_req = 1; srst_req = 1; sq_empty = 0; cmp_valid = 1; cmp_fault = 11'h010;
        expect_take(5'd1, "R2 hard reset first");
        tick();
        hrst_req = 0; cmp_valid = 0; cmp_fault = '0;
        // R4 soft reset waits for recoverable state
        quiet(3, "R4 soft reset held while not recoverable");
        sq_empty = 1;
        expect_take(5'd3, "R4 soft reset once recoverable");
        tick();
        srst_req = 0;
        quiet(1, "R4 no repeat");

        // R3 machine check with soft reset in same cycle
        mchk_req = 1; srst_req = 1;
        expect_take(5'd2, "R3 machine check before soft reset");
        expect_take(5'd3, "R3 soft reset right after machine check");
        tick();
        mchk_req = 0;
        tick();
        srst_req = 0;
        mchk_req = 1; cmpl_idle = 0;
        expect_take(5'd2, "R3 machine check while not recoverable");
        tick();
        mchk_req = 0; cmpl_idle = 1;
        quiet(1, "R3 no repeat");

        // R6 fault priority
        cmp_valid = 1;
        cmp_fault = 11'h048; expect_take(5'd13, "R6 FP unavailable over alignment");
        tick();
        cmp_fault = 11'h600; expect_take(5'd19, "R6 page protection over data breakpoint");
        tick();
        cmp_fault = 11'h401; expect_take(5'd10, "R6 address breakpoint highest");
        tick();
        cmp_fault = 11'h020; expect_take(5'd15, "R6 external-control data fault");
        tick();
        cmp_valid = 0; cmp_fault = 11'h002;
        quiet(2, "R6 fault without valid ignored");
        cmp_fault = '0;

        // R7 trace
        cmp_valid = 1; trace_step = 1;
        expect_take(5'd21, "R7 single-step trace");
        tick();
        trace_step = 0; trace_branch = 1; cmp_branch = 1;
        expect_take(5'd21, "R7 branch trace");
        tick();
        cmp_branch = 0;
        quiet(1, "R7 branch trace skips non-branch");
        trace_step = 1; cmp_fault = 11'h004;
        expect_take(5'd12, "R7 fault replaces trace");
        tick();
        cmp_valid = 0; cmp_fault = '0; trace_step = 0; trace_branch = 0;
        quiet(2, "R7 dropped trace never taken");

        // R8 masking
        irq_req = 5'b00010;
        quiet(3, "R8 global enable clear");
        check(cmp_halt == 0, "R8 no halt with global enable clear", int'(cmp_halt), 0);
        irq_ee = 1; irq_en = 5'b11101;
        quiet(2, "R8 line enable clear");
        cmp_valid = 1;
        quiet(1, "R8 retirement with masked line");
        cmp_valid = 0;
        tick();
        check(cmp_halt == 0, "R8 no halt with line disabled", int'(cmp_halt), 0);

        // R9 sequence
        irq_en = 5'h1f; sq_empty = 0;
        tick();
        check(cmp_halt == 0, "R9 waits for a retirement", int'(cmp_halt), 0);
        cmp_valid = 1;
        tick();
        check(cmp_halt == 1, "R9 halt after retirement", int'(cmp_halt), 1);
        cmp_fault = 11'h001;
        quiet(2, "R9 retirement ignored while halted");
        cmp_valid = 0; cmp_fault = '0;
        check(cmp_halt == 1, "R9 halt held", int'(cmp_halt), 1);
        sq_empty = 1;
        expect_take(5'd5, "R9 external interrupt once recoverable");
        tick();
        irq_req = '0;
        tick();
        check(cmp_halt == 0, "R9 halt released", int'(cmp_halt), 0);

        // R8 priority among lines
        irq_req = 5'b01100;
        tick();
        cmp_valid = 1;
        tick();
        cmp_valid = 0;
        expect_take(5'd6, "R8 performance monitor over decrementer");
        tick();
        irq_req = '0;
        tick();

        // R10 next instruction faults while interrupt waits
        irq_req = 5'b00010;
        tick();
        cmp_valid = 1; cmp_fault = 11'h004;
        expect_take(5'd12, "R10 instruction fault first");
        tick();
        check(cmp_halt == 0, "R10 no halt after faulting instruction", int'(cmp_halt), 0);
        cmp_fault = '0;
        tick();
        cmp_valid = 0;
        expect_take(5'd5, "R10 interrupt still pending");
        tick();
        irq_req = '0; irq_ee = 0;
        tick();

        // R11 fetch fault taken after drain
        fetch_fault = 1; inflight_empty = 0;
        tick();
        fetch_fault = 0;
        check(dispatch_stop == 1, "R11 dispatch stop raised", int'(dispatch_stop), 1);
        quiet(2, "R11 waits for drain");
        inflight_empty = 1; sq_empty = 0;
        quiet(1, "R11 waits for recoverable");
        sq_empty = 1;
        expect_take(5'd9, "R11 fetch fault taken");
        tick();
        check(dispatch_stop == 0, "R11 dispatch stop released", int'(dispatch_stop), 0);

        // R11 fetch fault dropped by older fault
        fetch_fault = 1; inflight_empty = 0;
        tick();
        fetch_fault = 0; cmp_valid = 1; cmp_fault = 11'h040;
        expect_take(5'd16, "R11 older alignment fault wins");
        tick();
        cmp_valid = 0; cmp_fault = '0; inflight_empty = 1;
        quiet(3, "R11 discarded fetch fault not taken");
        check(dispatch_stop == 0, "R11 dispatch stop cleared on drop", int'(dispatch_stop), 0);

        // R5 checkstop
        mchk_en = 0; mchk_req = 1;
        quiet(1, "R5 disabled machine check not taken");
        mchk_req = 0;
        check(checkstop == 1, "R5 checkstop raised", int'(checkstop), 1);
        hrst_req = 1;
        quiet(2, "R5 hard reset suppressed in checkstop");
        hrst_req = 0;
        check(checkstop == 1, "R5 checkstop sticky", int'(checkstop), 1);
        rst = 1; mchk_en = 1;
        tick(); tick();
        rst = 0;
        tick();
        check(checkstop == 0, "R1 checkstop cleared by reset", int'(checkstop), 0);

        check(exp_code.size() == 0, "R12 every expected take seen", exp_code.size(), 0);
        summary();
    end

endmodule